// File: doc/BRIEF.md
# Sprite XOR Draw Engine

This block draws a sprite into a one-bit-per-pixel frame buffer that lives in byte memory. The sprite is eight pixels wide and from 1 to 15 rows tall, with one byte per row. The most significant bit of each byte is the leftmost pixel. Each row is placed at a pixel column X and a line Y + row. The row is shifted right by X mod 8, so it can span two neighbouring frame-buffer bytes, and it is XORed into them. The engine reports whether any pixel that was lit got switched off.

A pulse on `start` while the engine is idle latches X, Y, the row count and the sprite source address. The engine then works through a fixed read–read–write sequence on its single byte-wide memory port, which has a one-cycle read latency. At the end it gives a one-cycle `done` pulse. The collision result stays on `collision` until the next accepted start. Software or a sequencer drives the strobe; the memory is shared with whatever holds the sprite data.

Top module: `sprite_xor_engine`

## Requirements
- R1: After reset `busy`, `done`, `collision`, `mem_rd` and `mem_wr` are all 0, and the memory strobes stay 0 whenever `busy` is 0.
- R2: For row r, the first frame-buffer byte is at (FB_BASE + (Y + r) × 8 + X / 8) mod 2^ADDR_W, with FB_BASE = 0xF00 and 12-bit addresses by default. The second byte is the next address, mod 2^ADDR_W.
- R3: The sprite byte for row r is read from (source address + r) mod 2^ADDR_W. Each row reads memory 3 times when X mod 8 ≠ 0 and 2 times when X mod 8 = 0.
- R4: With s the sprite byte and k = X mod 8, the 16-bit value {s, 0x00} >> k gives two bytes. Its upper byte is XORed into the first frame-buffer byte and its lower byte into the second. Bit 7 of a byte is its leftmost pixel.
- R5: When X mod 8 = 0, only the first byte of each row is written: one write per row. Otherwise each row writes two bytes.
- R6: `collision` is cleared by an accepted start. It becomes 1 if for any row (old first byte AND upper byte) or (old second byte AND lower byte) is nonzero. It then holds its value until the next accepted start.
- R7: `done` is high for exactly one cycle. It is seen N × C clock edges after the edge that accepted start, with C = 5 when X mod 8 ≠ 0 and C = 3 otherwise. `busy` is high from the accepting edge through the `done` cycle and low after it.
- R8: A start with a row count of 0 produces `done` in the cycle right after the accepting edge. It makes no memory access and leaves `collision` at 0.
- R9: A start that arrives while `busy` is high is ignored. The draw in progress keeps its latched coordinates, count and timing, and no second draw follows.
- R10: Read data is taken one cycle after `mem_rd`, and `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Draw request, accepted only when idle |
| x_pos | input | 6 | Pixel column of the sprite's left edge |
| y_pos | input | 5 | Line of the sprite's top row |
| n_rows | input | 4 | Number of sprite rows, 0 to 15 |
| spr_addr | input | 12 | Address of the first sprite byte |
| mem_addr | output | 12 | Memory byte address |
| mem_rd | output | 1 | Read strobe; data returns on the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd` |
| busy | output | 1 | Draw in progress |
| done | output | 1 | One-cycle completion pulse |
| collision | output | 1 | A lit pixel was cleared by the last draw |

## Verification
Frame-buffer bytes change on the write edges inside each row, and those come 3 or 5 cycles per row after the accepting edge. `done` is due exactly N × C edges after that edge. The bench counts falling edges from the accepting edge, expects `done` at that count and one edge later expects `busy` and `done` low. It reads `collision` and compares the whole memory against an arithmetic reference only at the `done` cycle and after it, when every write has been committed. Read and write counts are taken as differences across the whole draw, so they do not depend on the position of any single access.

// File: rtl/spr_pkg.sv
package spr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_SPR = 3'd1,
    ST_RD_FB0 = 3'd2,
    ST_RD_FB1 = 3'd3,
    ST_WR_FB0 = 3'd4,
    ST_WR_FB1 = 3'd5,
    ST_DONE   = 3'd6
  } spr_state_e;

  localparam int unsigned PIX_PER_BYTE = 8;
  localparam int unsigned SHIFT_W      = 3;

endpackage

// File: rtl/spr_row_merge.sv
module spr_row_merge
  import spr_pkg::*;
(
  input  logic [7:0]         spr_byte,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [7:0]         old0,
  input  logic [7:0]         old1,
  output logic [7:0]         new0,
  output logic [7:0]         new1,
  output logic               hit0,
  output logic               hit1
);

  logic [15:0] aligned_w;
  logic [7:0]  part_hi;
  logic [7:0]  part_lo;

  always_comb begin
    aligned_w = {spr_byte, 8'h00} >> shift;
    part_hi   = aligned_w[15:8];
    part_lo   = aligned_w[7:0];
  end

  // Per-pixel combine: XOR toggles, AND detects a lit pixel being cleared.
  for (genvar b = 0; b < PIX_PER_BYTE; b++) begin : g_pix
    assign new0[b] = old0[b] ^ part_hi[b];
    assign new1[b] = old1[b] ^ part_lo[b];
  end

  assign hit0 = |(old0 & part_hi);
  assign hit1 = |(old1 & part_lo);

endmodule

// File: rtl/spr_addr_gen.sv
module spr_addr_gen
  import spr_pkg::*;
#(
  parameter int unsigned            ADDR_W        = 12,
  parameter int unsigned            X_W           = 6,
  parameter int unsigned            Y_W           = 5,
  parameter int unsigned            N_W           = 4,
  parameter int unsigned            BYTES_PER_ROW = 8,
  parameter logic [ADDR_W-1:0]      FB_BASE       = 12'hF00
) (
  input  spr_state_e        state,
  input  logic [X_W-1:0]    x_q,
  input  logic [Y_W-1:0]    y_q,
  input  logic [N_W-1:0]    row_q,
  input  logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] mem_addr
);

  localparam int unsigned COL_W = X_W - SHIFT_W;

  logic [COL_W-1:0]  col;
  logic [ADDR_W-1:0] line_idx;
  logic [ADDR_W-1:0] fb_addr0;
  logic [ADDR_W-1:0] fb_addr1;
  logic [ADDR_W-1:0] spr_row_addr;

  always_comb begin
    col          = x_q[X_W-1:SHIFT_W];
    line_idx     = ADDR_W'(y_q) + ADDR_W'(row_q);
    fb_addr0     = FB_BASE + line_idx * ADDR_W'(BYTES_PER_ROW) + ADDR_W'(col);
    fb_addr1     = fb_addr0 + ADDR_W'(1);
    spr_row_addr = src_q + ADDR_W'(row_q);
  end

  always_comb begin
    unique case (state)
      ST_RD_SPR:            mem_addr = spr_row_addr;
      ST_RD_FB0, ST_WR_FB0: mem_addr = fb_addr0;
      ST_RD_FB1, ST_WR_FB1: mem_addr = fb_addr1;
      default:              mem_addr = '0;
    endcase
  end

endmodule

// File: rtl/spr_ctrl.sv
module spr_ctrl
  import spr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       n_zero,
  input  logic       aligned,
  input  logic       last_row,
  output spr_state_e state,
  output logic       accept,
  output logic       row_done,
  output logic       busy,
  output logic       done
);

  spr_state_e state_q;
  spr_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = n_zero ? ST_DONE : ST_RD_SPR;
      ST_RD_SPR: state_d = ST_RD_FB0;
      ST_RD_FB0: state_d = aligned ? ST_WR_FB0 : ST_RD_FB1;
      ST_RD_FB1: state_d = ST_WR_FB0;
      ST_WR_FB0: begin
        if (!aligned)     state_d = ST_WR_FB1;
        else if (last_row) state_d = ST_DONE;
        else               state_d = ST_RD_SPR;
      end
      ST_WR_FB1: state_d = last_row ? ST_DONE : ST_RD_SPR;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state    = state_q;
  assign accept   = (state_q == ST_IDLE) && start;
  assign row_done = ((state_q == ST_WR_FB0) && aligned) || (state_q == ST_WR_FB1);
  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_DONE);

endmodule

// File: rtl/sprite_xor_engine.sv
module sprite_xor_engine
  import spr_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 12,
  parameter int unsigned       FB_W_PIX   = 64,
  parameter int unsigned       FB_LINES   = 32,
  parameter int unsigned       N_W        = 4,
  parameter int unsigned       RST_STAGES = 2,
  parameter logic [ADDR_W-1:0] FB_BASE    = 12'hF00
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [$clog2(FB_W_PIX)-1:0] x_pos,
  input  logic [$clog2(FB_LINES)-1:0] y_pos,
  input  logic [N_W-1:0]              n_rows,
  input  logic [ADDR_W-1:0]           spr_addr,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic                        mem_rd,
  output logic                        mem_wr,
  output logic [7:0]                  mem_wdata,
  input  logic [7:0]                  mem_rdata,
  output logic                        busy,
  output logic                        done,
  output logic                        collision
);

  localparam int unsigned X_W           = $clog2(FB_W_PIX);
  localparam int unsigned Y_W           = $clog2(FB_LINES);
  localparam int unsigned BYTES_PER_ROW = FB_W_PIX / PIX_PER_BYTE;

  // ---------------- reset synchronizer (async assert, sync release)
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_n_int;

  for (genvar s = 0; s < RST_STAGES; s++) begin : g_rst
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe[s] <= 1'b0;
        else        rst_pipe[s] <= 1'b1;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe[s] <= 1'b0;
        else        rst_pipe[s] <= rst_pipe[s-1];
      end
    end
  end
  assign rst_n_int = rst_pipe[RST_STAGES-1];

  // ---------------- control
  spr_state_e state;
  logic       accept;
  logic       row_done;
  logic       aligned;
  logic       last_row;
  logic       n_zero;

  logic [X_W-1:0]    x_q,    x_d;
  logic [Y_W-1:0]    y_q,    y_d;
  logic [N_W-1:0]    n_q,    n_d;
  logic [ADDR_W-1:0] src_q,  src_d;
  logic [N_W-1:0]    row_q,  row_d;
  logic [7:0]        spr_q,  spr_d;
  logic [7:0]        old0_q, old0_d;
  logic [7:0]        old1_q, old1_d;
  logic              coll_q, coll_d;

  logic              ld_params, ld_spr, ld_old0, ld_old1, ld_row, ld_coll;

  assign n_zero   = (n_rows == '0);
  assign aligned  = (x_q[SHIFT_W-1:0] == '0);
  assign last_row = (row_q == n_q - N_W'(1));

  spr_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start    (start),
    .n_zero   (n_zero),
    .aligned  (aligned),
    .last_row (last_row),
    .state    (state),
    .accept   (accept),
    .row_done (row_done),
    .busy     (busy),
    .done     (done)
  );

  // ---------------- address generation
  spr_addr_gen #(
    .ADDR_W        (ADDR_W),
    .X_W           (X_W),
    .Y_W           (Y_W),
    .N_W           (N_W),
    .BYTES_PER_ROW (BYTES_PER_ROW),
    .FB_BASE       (FB_BASE)
  ) u_addr (
    .state    (state),
    .x_q      (x_q),
    .y_q      (y_q),
    .row_q    (row_q),
    .src_q    (src_q),
    .mem_addr (mem_addr)
  );

  // ---------------- pixel combine
  logic [7:0] old0_eff;
  logic [7:0] new0, new1;
  logic       hit0, hit1;

  // Aligned rows write in the cycle right after the screen read returns.
  assign old0_eff = aligned ? mem_rdata : old0_q;

  spr_row_merge u_merge (
    .spr_byte (spr_q),
    .shift    (x_q[SHIFT_W-1:0]),
    .old0     (old0_eff),
    .old1     (old1_q),
    .new0     (new0),
    .new1     (new1),
    .hit0     (hit0),
    .hit1     (hit1)
  );

  // ---------------- next-state for datapath registers
  always_comb begin
    ld_params = accept;
    ld_row    = accept || row_done;
    ld_spr    = (state == ST_RD_FB0);
    ld_old0   = (state == ST_RD_FB1);
    ld_old1   = (state == ST_WR_FB0) && !aligned;
    ld_coll   = accept || (state == ST_WR_FB0) || (state == ST_WR_FB1);

    x_d    = x_pos;
    y_d    = y_pos;
    n_d    = n_rows;
    src_d  = spr_addr;
    row_d  = accept ? '0 : row_q + N_W'(1);
    spr_d  = mem_rdata;
    old0_d = mem_rdata;
    old1_d = mem_rdata;

    if (accept)                  coll_d = 1'b0;
    else if (state == ST_WR_FB0) coll_d = coll_q | hit0;
    else                         coll_d = coll_q | hit1;
  end

  // ---------------- registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      x_q   <= '0;
      y_q   <= '0;
      n_q   <= '0;
      src_q <= '0;
    end else if (ld_params) begin
      x_q   <= x_d;
      y_q   <= y_d;
      n_q   <= n_d;
      src_q <= src_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  row_q <= '0;
    else if (ld_row) row_q <= row_d;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  spr_q <= '0;
    else if (ld_spr) spr_q <= spr_d;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)   old0_q <= '0;
    else if (ld_old0) old0_q <= old0_d;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)   old1_q <= '0;
    else if (ld_old1) old1_q <= old1_d;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)   coll_q <= 1'b0;
    else if (ld_coll) coll_q <= coll_d;
  end

  // ---------------- memory port
  always_comb begin
    mem_rd    = (state == ST_RD_SPR) || (state == ST_RD_FB0) || (state == ST_RD_FB1);
    mem_wr    = (state == ST_WR_FB0) || (state == ST_WR_FB1);
    mem_wdata = (state == ST_WR_FB1) ? new1 : new0;
  end

  assign collision = coll_q;

endmodule

// File: rtl/sprite_xor_engine_chk.sv
module sprite_xor_engine_chk #(
  parameter int unsigned N_W = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [N_W-1:0] n_rows,
  input logic           busy,
  input logic           done,
  input logic           collision,
  input logic           mem_rd,
  input logic           mem_wr
);

  assert_port_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> !collision);

  assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(collision));

  assert_empty_draw_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (n_rows == '0)) |=> (done && !collision));

  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);

endmodule

bind sprite_xor_engine sprite_xor_engine_chk #(.N_W(N_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .n_rows    (n_rows),
  .busy      (busy),
  .done      (done),
  .collision (collision),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr)
);

// File: tb/sprite_xor_engine_test.sv
`timescale 1ns/1ps
module sprite_xor_engine_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [5:0]  x_pos;
  logic [4:0]  y_pos;
  logic [3:0]  n_rows;
  logic [11:0] spr_addr;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        busy, done, collision;

  always #2.5 clk = ~clk;

  sprite_xor_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .x_pos(x_pos), .y_pos(y_pos),
    .n_rows(n_rows), .spr_addr(spr_addr), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .collision(collision)
  );

  // bench memory: one-cycle read latency, plus a preload port
  logic [7:0]  ram     [0:4095];
  logic [7:0]  ref_mem [0:4095];
  logic        tb_we = 1'b0;
  logic [11:0] tb_a  = '0;
  logic [7:0]  tb_d  = '0;
  int          rd_cnt = 0, wr_cnt = 0, clash_cnt = 0;

  always @(posedge clk) begin
    if (tb_we)  ram[tb_a] <= tb_d;
    if (mem_wr) ram[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= ram[mem_addr];
    if (mem_rd) rd_cnt <= rd_cnt + 1;
    if (mem_wr) wr_cnt <= wr_cnt + 1;
    if (mem_rd && mem_wr) clash_cnt <= clash_cnt + 1;
  end

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic poke(input int a, input int d);
    @(negedge clk);
    tb_we = 1'b1; tb_a = 12'(a); tb_d = 8'(d);
    ref_mem[a % 4096] = 8'(d);
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  // arithmetic reference of one draw
  task automatic ref_draw(input int x, input int y, input int n, input int src,
                          output int coll);
    coll = 0;
    for (int r = 0; r < n; r++) begin
      logic [7:0]  s;
      logic [15:0] w;
      int a0, a1, sh;
      s  = ref_mem[(src + r) % 4096];
      sh = x % 8;
      w  = {s, 8'h00} >> sh;
      a0 = (3840 + (y + r) * 8 + x / 8) % 4096;
      a1 = (a0 + 1) % 4096;
      if ((ref_mem[a0] & w[15:8]) != 0) coll = 1;
      ref_mem[a0] = ref_mem[a0] ^ w[15:8];
      if (sh != 0) begin
        if ((ref_mem[a1] & w[7:0]) != 0) coll = 1;
        ref_mem[a1] = ref_mem[a1] ^ w[7:0];
      end
    end
  endtask

  task automatic run_draw(input int x, input int y, input int n, input int src,
                          input bit inject, output int coll_seen);
    int exp_coll, cost, k, rd0, wr0, mism;
    string treq;
    ref_draw(x, y, n, src, exp_coll);
    cost = (x % 8 == 0) ? 3 : 5;
    treq = (n == 0) ? "R8" : (inject ? "R9" : "R7");
    @(negedge clk);
    x_pos = 6'(x); y_pos = 5'(y); n_rows = 4'(n); spr_addr = 12'(src);
    start = 1'b1;
    rd0 = rd_cnt; wr0 = wr_cnt;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!done && k < 400) begin
      if (inject && k == 1) begin
        start = 1'b1; x_pos = x_pos ^ 6'd5; y_pos = y_pos ^ 5'd3;
        n_rows = 4'd15; spr_addr = spr_addr ^ 12'h011;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    check(k == n * cost, treq, "done latency", k, n * cost);       // R7 / R8 / R9
    check(collision == exp_coll[0], (n == 0) ? "R8" : "R6", "collision at done",
          int'(collision), exp_coll);
    coll_seen = int'(collision);
    @(negedge clk);
    check(!done && !busy, inject ? "R9" : "R7", "done/busy after pulse",
          int'({done, busy}), 0);
    check(collision == exp_coll[0], "R6", "collision held", int'(collision), exp_coll);
    check(rd_cnt - rd0 == n * ((cost == 5) ? 3 : 2), (n == 0) ? "R8" : "R3",
          "read count", rd_cnt - rd0, n * ((cost == 5) ? 3 : 2));
    check(wr_cnt - wr0 == n * ((cost == 5) ? 2 : 1), (n == 0) ? "R8" : "R5",
          "write count", wr_cnt - wr0, n * ((cost == 5) ? 2 : 1));
    mism = 0;
    for (int a = 0; a < 4096; a++) if (ram[a] !== ref_mem[a]) mism++;
    check(mism == 0, "R2", "memory bytes differing from R4 XOR model", mism, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int cs;
    rst_n = 1'b0; start = 1'b0; x_pos = '0; y_pos = '0; n_rows = '0; spr_addr = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({busy, done, collision, mem_rd, mem_wr} == 5'b0, "R1", "outputs in reset",
          int'({busy, done, collision, mem_rd, mem_wr}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({busy, done, collision, mem_rd, mem_wr} == 5'b0, "R1", "outputs after reset",
          int'({busy, done, collision, mem_rd, mem_wr}), 0);

    // preload whole memory with a pattern (frame buffer and sprites)
    for (int a = 0; a < 4096; a++) poke(a, ((a * 29) ^ (a >> 4) ^ 8'h5A) & 8'hFF);

    // R6: clean area, draw then redraw: first no hit, second hit and erased
    for (int a = 12'hF10; a < 12'hF30; a++) poke(a, 0);
    poke(12'h800, 8'h81); poke(12'h801, 8'hFF); poke(12'h802, 8'h3C); poke(12'h803, 8'h01);
    run_draw(13, 2, 4, 12'h800, 1'b0, cs);
    check(cs == 0, "R6", "no hit on blank area", cs, 0);
    run_draw(13, 2, 4, 12'h800, 1'b0, cs);
    check(cs == 1, "R6", "hit when redrawn", cs, 1);
    begin
      int nz = 0;
      for (int a = 12'hF10; a < 12'hF30; a++) if (ram[a] != 8'h00) nz++;
      check(nz == 0, "R4", "redraw restores blank bytes", nz, 0);
    end

    // R2/R4/R5/R7/R8/R9: sweep every column, varied lines and counts
    for (int x = 0; x < 64; x++) begin
      run_draw(x, (x * 7) % 32, x % 16, 12'h400 + x * 9, (x % 4 == 1) && (x % 16 != 0), cs);
    end

    // R2: bottom lines wrap the address space, tallest sprites
    for (int x = 0; x < 64; x += 5) begin
      run_draw(x, 31 - (x % 4), 15, 12'h600 + x, 1'b0, cs);
    end

    check(clash_cnt == 0, "R10", "cycles with read and write together", clash_cnt, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule